// File: doc/BRIEF.md
# Seven-Input Stacking Population Counter

This block counts how many of seven equal-weight input bits are set and presents the result as a 3-bit binary number. It is meant as a column compressor inside an arithmetic datapath, where a wide column of partial-product bits of the same weight must be reduced to a short binary value.

The count is formed in two steps. The first step sorts the set bits into a contiguous run, using only AND and OR gates. Small three-input sorting cells each pack their ones toward bit 0. Pairs of sorted runs are then merged into one longer sorted run. The seventh input joins as a one-bit run in a second merge. The second step reads the sorted run, which is a thermometer code, and converts it to binary. Parity is recovered from the edge of the thermometer code rather than from an XOR chain over the raw inputs.

The sorted run is also brought out as a port, so a consumer can use the thermometer form directly. The block is purely combinational.

Top module: `pop7_stack_counter`

## Requirements
- R1: For every one of the 128 input patterns, `count_o` equals the number of set bits in `bits_i`.
- R2: `stack_o` is a thermometer code: bit k is 1 exactly when at least k+1 inputs are 1. Its ones therefore occupy bits 0 upward with no gap.
- R3: `stack_o` holds exactly as many ones as `bits_i`, whichever input positions carry them.
- R4: With all inputs 0, `count_o` is 0 and `stack_o` is 7'h00.
- R5: With all inputs 1, `count_o` is 7 and `stack_o` is 7'h7F.
- R6: `count_o[2]` is 1 exactly when four or more inputs are 1.
- R7: `count_o[1]` is 1 exactly when the number of set inputs is 2, 3, 6 or 7.
- R8: `count_o[0]` equals the parity (XOR) of all seven inputs.
- R9: The outputs follow an input change with no clock edge involved; the block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bits_i | input | 7 | Seven input bits of equal weight |
| stack_o | output | 7 | Inputs sorted into a thermometer code, ones from bit 0 upward |
| count_o | output | 3 | Binary number of set inputs, 0 to 7 |

## Verification
The hardest situation to reach from the ports is a merge in which both three-bit runs and the lone seventh bit are partly filled at the same time. Only in that case do the cross terms of both merge layers decide a middle thermometer bit. Such patterns make up a small part of the input space. The stimulus therefore sweeps all 128 patterns, so every split of ones between the two groups and the seventh bit is applied. Each pattern is checked both after a clock edge and again after a purely combinational input change.

// File: rtl/pop7_pkg.sv
package pop7_pkg;
    localparam int N_IN  = 7;
    localparam int GRP_W = 3;
    localparam int CNT_W = $clog2(N_IN + 1);

    typedef logic [N_IN-1:0]  therm_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        therm_t stack;
        cnt_t   count;
    } result_t;
endpackage

// File: rtl/stack3_cell.sv
// Three-input sorter: moves the ones toward bit 0 using AND/OR logic only.
module stack3_cell (
    input  logic [2:0] x_i,
    output logic [2:0] y_o
);
    always_comb begin
        y_o[0] = x_i[0] | x_i[1] | x_i[2];
        y_o[1] = (x_i[0] & x_i[1]) | (x_i[0] & x_i[2]) | (x_i[1] & x_i[2]);
        y_o[2] = x_i[0] & x_i[1] & x_i[2];
    end
endmodule

// File: rtl/stack_merge.sv
// Symmetric merge of two sorted runs into one sorted run.
// Output bit k is set when run A holds at least i ones and run B holds at
// least j ones for some i+j = k+1. A count of zero is always satisfied.
module stack_merge #(
    parameter  int LA = 3,
    parameter  int LB = 3,
    localparam int LO = LA + LB
) (
    input  logic [LA-1:0] a_i,
    input  logic [LB-1:0] b_i,
    output logic [LO-1:0] m_o
);
    logic [LA:0] ax;
    logic [LB:0] bx;

    assign ax = {a_i, 1'b1};
    assign bx = {b_i, 1'b1};

    always_comb begin
        m_o = '0;
        for (int i = 0; i <= LA; i++) begin
            for (int j = 0; j <= LB; j++) begin
                if (i + j >= 1) begin
                    m_o[i + j - 1] = m_o[i + j - 1] | (ax[i] & bx[j]);
                end
            end
        end
    end
endmodule

// File: rtl/therm_to_bin.sv
// Converts a thermometer code to binary by locating its single edge.
module therm_to_bin #(
    parameter  int N = 7,
    localparam int W = $clog2(N + 1)
) (
    input  logic [N-1:0] t_i,
    output logic [W-1:0] bin_o
);
    logic [N:0] tx;
    assign tx = {1'b0, t_i};

    always_comb begin
        bin_o = '0;
        for (int c = 1; c <= N; c++) begin
            if (tx[c-1] & ~tx[c]) begin
                bin_o = bin_o | W'(c);
            end
        end
    end
endmodule

// File: rtl/pop7_stack_counter.sv
module pop7_stack_counter
    import pop7_pkg::*;
(
    input  logic [6:0] bits_i,
    output logic [6:0] stack_o,
    output logic [2:0] count_o
);
    localparam int PAIR_W = 2 * GRP_W;
    localparam int ODD_W  = N_IN - PAIR_W;

    logic [GRP_W-1:0]  grp_stk [2];
    logic [PAIR_W-1:0] pair_stk;
    therm_t            full_stk;
    cnt_t              full_cnt;
    result_t           res_d;

    for (genvar g = 0; g < 2; g++) begin : g_grp
        stack3_cell i_cell (
            .x_i (bits_i[g*GRP_W +: GRP_W]),
            .y_o (grp_stk[g])
        );
    end

    stack_merge #(.LA(GRP_W), .LB(GRP_W)) i_merge_pair (
        .a_i (grp_stk[0]),
        .b_i (grp_stk[1]),
        .m_o (pair_stk)
    );

    stack_merge #(.LA(PAIR_W), .LB(ODD_W)) i_merge_odd (
        .a_i (pair_stk),
        .b_i (bits_i[N_IN-1 -: ODD_W]),
        .m_o (full_stk)
    );

    therm_to_bin #(.N(N_IN)) i_enc (
        .t_i   (full_stk),
        .bin_o (full_cnt)
    );

    always_comb begin
        res_d       = '0;
        res_d.stack = full_stk;
        res_d.count = full_cnt;
    end

    assign stack_o = res_d.stack;
    assign count_o = res_d.count;
endmodule

// File: rtl/pop7_stack_counter_chk.sv
module pop7_stack_counter_chk (
    input logic [6:0] bits_i,
    input logic [6:0] stack_o,
    input logic [2:0] count_o
);
    always_comb begin
        if (!$isunknown({bits_i, stack_o, count_o})) begin
            AST_COUNT_MATCH: assert (32'(count_o) == $countones(bits_i)) else $error("count mismatch"); // R1
            AST_THERM_SHAPE: assert (((stack_o + 7'd1) & stack_o) == 7'd0) else $error("stack not contiguous"); // R2
            AST_ONES_KEPT: assert ($countones(stack_o) == $countones(bits_i)) else $error("ones lost"); // R3
            AST_ALL_ZERO: assert (bits_i != 7'h00 || (count_o == 3'd0 && stack_o == 7'h00)) else $error("zero case"); // R4
            AST_ALL_ONE: assert (bits_i != 7'h7F || (count_o == 3'd7 && stack_o == 7'h7F)) else $error("full case"); // R5
            AST_HALF_BIT: assert (count_o[2] == ($countones(bits_i) >= 4)) else $error("bit2"); // R6
            AST_PARITY: assert (count_o[0] == ^bits_i) else $error("parity"); // R8
        end
    end
endmodule

bind pop7_stack_counter pop7_stack_counter_chk i_chk (.*);

// File: tb/test_pop7_stack_counter.sv
`timescale 1ns/1ps
module test_pop7_stack_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] bits_i;
    logic [6:0] stack_o;
    logic [2:0] count_o;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    always #4 clk = ~clk;

    pop7_stack_counter i_pop7_stack_counter (
        .bits_i  (bits_i),
        .stack_o (stack_o),
        .count_o (count_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (in=%b)", req, act, exp, bits_i);
        end
    endtask

    task automatic check_all(input logic [6:0] v);
        int n = 0;
        for (int b = 0; b < 7; b++) n += int'(v[b]);
        chk("R1", int'(count_o), n);
        chk("R2", int'(stack_o), (1 << n) - 1);
        chk("R3", $countones(stack_o), n);
        chk("R6", int'(count_o[2]), (n >= 4) ? 1 : 0);
        chk("R7", int'(count_o[1]), (n == 2 || n == 3 || n == 6 || n == 7) ? 1 : 0);
        chk("R8", int'(count_o[0]), n % 2);
    endtask

    initial begin
        bits_i = 7'h00;
        repeat (3) @(posedge clk);
        #1;
        chk("R4", int'(count_o), 0);
        chk("R4", int'(stack_o), 0);
        rst = 1'b0;
        for (int p = 0; p < 128; p++) begin
            @(negedge clk);
            bits_i = 7'(p);
            #2;
            check_all(7'(p));
            // R9: change input mid-cycle, no clock edge before sampling
            bits_i = 7'(127 - p);
            #1;
            check_all(7'(127 - p));
        end
        @(negedge clk);
        bits_i = 7'h7F;
        #1;
        chk("R5", int'(count_o), 7);
        chk("R5", int'(stack_o), 127);
        bits_i = 7'h00;
        #1;
        chk("R4", int'(count_o), 0);
        chk("R4", int'(stack_o), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule